// File: doc/BRIEF.md
# Scanout Position Resolver

The resolver turns one raw sample from a display timing generator into a corrected scanout position. The result has three parts: a signed vertical line, a horizontal pixel and an in-vblank flag. A mode input selects the raw source. In line mode the source is the scanline counter, which counts whole lines. In pixel mode the source is the frame pixel counter, which counts single pixels from the start of the frame. Each source needs a fixed correction before use, because the raw counters advance at the leading edge of horizontal sync. The resolver defines a line, and vblank, as starting at the leading edge of horizontal active.

Each request presents the raw sample and the current mode timing (htotal, hsync start, vtotal, vblank start and vblank end) together with a one-cycle `start_i`. The resolver latches the request and runs one shared restoring divider once or twice. The first pass wraps the position into the frame. In pixel mode a second pass splits the position into a line and a pixel. The resolver then sets the vblank flag and the signed line. `done_o` pulses once when the results are presented. A `start_i` that arrives while the block is busy is dropped.

Top module: `scanpos_resolver`

## Requirements
- R1: In line mode, only the low LINE_W bits of `raw_line_i` are used (12 bits by default, so bit 12 of the 13-bit input is dropped). The line is (masked + 1) mod vtotal, and `hpos_o` is 0.
- R2: In pixel mode, the position is (raw_pix + htotal - hsync_start) mod (htotal*vtotal). The line is position / htotal and `hpos_o` is position mod htotal.
- R3: In pixel mode, vblank start and vblank end are scaled by htotal and compared with the pixel position. A sample whose raw value is htotal*(vblank_start-1)+hsync_start therefore already reports in-vblank, on line vblank_start at pixel 0.
- R4: When vblank_start < vblank_end, the position is in vblank if it is at or after the start bound and before the end bound. Otherwise the vblank interval wraps across the frame boundary, and the position is in vblank if it is at or after the start bound, or before the end bound.
- R5: `vpos_o` is a (LINE_W+1)-bit two's complement value. It equals line - vtotal when `in_vblank_o` is 1, and equals line otherwise.
- R6: A `start_i` accepted while idle raises `busy_o` on the next cycle. `done_o` is a one-cycle pulse during which `busy_o` is still 1. The outputs change only in the cycle of `done_o` and hold their values afterwards.
- R7: A `start_i` that arrives while busy is ignored. It produces no extra `done_o`, and the running request finishes with the values latched when it was accepted.
- R8: After reset `busy_o`, `done_o`, `vpos_o`, `hpos_o` and `in_vblank_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| pix_mode_i | input | 1 | 1 selects the pixel counter, 0 selects the scanline counter |
| raw_line_i | input | RAW_W | Raw scanline register value |
| raw_pix_i | input | PIX_W | Raw frame pixel counter value |
| htotal_i | input | LINE_W | Pixels per line |
| hsync_start_i | input | LINE_W | Pixel index of the hsync leading edge |
| vtotal_i | input | LINE_W | Lines per frame |
| vbl_start_i | input | LINE_W | First line of vblank |
| vbl_end_i | input | LINE_W | First line after vblank |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when the results are presented |
| vpos_o | output | LINE_W+1 | Signed corrected line |
| hpos_o | output | LINE_W | Corrected pixel within the line |
| in_vblank_o | output | 1 | Position lies inside vblank |

## Verification
Line mode is driven with three kinds of sample: the last line of the frame, which must wrap to 0; a sample with the high register bit set, which shows whether the mask is applied; and a value past vtotal, which shows whether a true modulo is taken. Pixel mode is driven with the two samples on either side of the vblank-start sync edge. These show whether the htotal-hsync_start offset moves the edge to pixel 0 of line vblank_start. Further pixel-mode cases are the last pixel of the frame, a count several frames long, and a sweep of spaced samples that compares every split into line and pixel. A second timing setup with a wrapped vblank interval separates the AND-form window test from the OR-form one. A start pulsed during a busy request shows whether the request is dropped.

// File: rtl/scanpos_pkg.sv
package scanpos_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRAP,
      ST_SPLIT,
      ST_JUDGE,
      ST_DONE
   } spr_state_e;

   function automatic int unsigned spr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spr_divider.sv
module spr_divider #(
   parameter int unsigned DW = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          fin,
   output logic [DW-1:0] quo,
   output logic [DW-1:0] rem
);
   localparam int unsigned CW = $clog2(DW + 1);

   logic [DW-1:0] r_q, q_q, d_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, fin_q;
   logic [DW:0]   r_sh, diff;

   always_comb begin
      r_sh = {r_q, q_q[DW-1]};
      diff = r_sh - {1'b0, d_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q   <= '0;
         q_q   <= '0;
         d_q   <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            r_q   <= '0;
            q_q   <= num;
            d_q   <= den;
            cnt_q <= CW'(DW);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (!diff[DW]) begin
               r_q <= diff[DW-1:0];
               q_q <= {q_q[DW-2:0], 1'b1};
            end else begin
               r_q <= r_sh[DW-1:0];
               q_q <= {q_q[DW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin = fin_q;
   assign quo = q_q;
   assign rem = r_q;
endmodule

// File: rtl/spr_offset.sv
module spr_offset #(
   parameter int unsigned LINE_W = 12,
   parameter int unsigned RAW_W  = 13,
   parameter int unsigned PIX_W  = 24,
   parameter int unsigned DW     = 25
) (
   input  logic              pix_mode,
   input  logic [RAW_W-1:0]  raw_line,
   input  logic [PIX_W-1:0]  raw_pix,
   input  logic [LINE_W-1:0] htotal,
   input  logic [LINE_W-1:0] hsync_start,
   input  logic [LINE_W-1:0] vtotal,
   output logic [DW-1:0]     dividend,
   output logic [DW-1:0]     modulus
);
   logic [LINE_W-1:0] line_field;

   generate
      if (RAW_W > LINE_W) begin : g_mask
         assign line_field = raw_line[LINE_W-1:0];
         logic unused_hi;
         assign unused_hi = ^raw_line[RAW_W-1:LINE_W];
      end else begin : g_plain
         assign line_field = raw_line[LINE_W-1:0];
      end
   endgenerate

   always_comb begin
      if (pix_mode) begin
         dividend = DW'(raw_pix) + DW'(htotal) - DW'(hsync_start);
         modulus  = DW'(htotal) * DW'(vtotal);
      end else begin
         dividend = DW'(line_field) + DW'(1);
         modulus  = DW'(vtotal);
      end
   end
endmodule

// File: rtl/spr_window.sv
module spr_window #(
   parameter int unsigned LINE_W = 12,
   parameter int unsigned DW     = 25
) (
   input  logic                     pix_mode,
   input  logic [DW-1:0]            pos,
   input  logic [LINE_W-1:0]        line,
   input  logic [LINE_W-1:0]        htotal,
   input  logic [LINE_W-1:0]        vtotal,
   input  logic [LINE_W-1:0]        vbl_start,
   input  logic [LINE_W-1:0]        vbl_end,
   output logic                     in_vbl,
   output logic signed [LINE_W:0]   vpos
);
   logic [DW-1:0] scale, start_b, end_b;
   logic          at_or_after, before_end, wraps;

   always_comb begin
      scale       = pix_mode ? DW'(htotal) : DW'(1);
      start_b     = DW'(vbl_start) * scale;
      end_b       = DW'(vbl_end) * scale;
      at_or_after = (pos >= start_b);
      before_end  = (pos < end_b);
      wraps       = (vbl_start >= vbl_end);
      in_vbl      = wraps ? (at_or_after | before_end) : (at_or_after & before_end);
      vpos        = in_vbl ? ($signed({1'b0, line}) - $signed({1'b0, vtotal}))
                           : $signed({1'b0, line});
   end
endmodule

// File: rtl/scanpos_resolver.sv
module scanpos_resolver
   import scanpos_pkg::*;
#(
   parameter int unsigned LINE_W = 12,
   parameter int unsigned RAW_W  = 13,
   parameter int unsigned PIX_W  = 24
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   pix_mode_i,
   input  logic [RAW_W-1:0]       raw_line_i,
   input  logic [PIX_W-1:0]       raw_pix_i,
   input  logic [LINE_W-1:0]      htotal_i,
   input  logic [LINE_W-1:0]      hsync_start_i,
   input  logic [LINE_W-1:0]      vtotal_i,
   input  logic [LINE_W-1:0]      vbl_start_i,
   input  logic [LINE_W-1:0]      vbl_end_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic signed [LINE_W:0] vpos_o,
   output logic [LINE_W-1:0]      hpos_o,
   output logic                   in_vblank_o
);
   localparam int unsigned DW = spr_max(PIX_W + 1, 2 * LINE_W);

   generate
      if (RAW_W < LINE_W) begin : g_bad_raw
         $error("RAW_W must be at least LINE_W");
      end
      if (LINE_W < 2) begin : g_bad_line
         $error("LINE_W must be at least 2");
      end
   endgenerate

   spr_state_e        state_q;
   logic              mode_q;
   logic [LINE_W-1:0] htot_q, vtot_q, vbs_q, vbe_q;
   logic [DW-1:0]     pos_q;
   logic [LINE_W-1:0] line_q, hp_q;

   logic [DW-1:0]     off_num, off_mod;
   logic              div_go, div_fin;
   logic [DW-1:0]     div_num, div_den, div_quo, div_rem;
   logic              win_in;
   logic signed [LINE_W:0] win_vpos;
   logic              accept;

   assign accept = start_i && (state_q == ST_IDLE);

   spr_offset #(.LINE_W(LINE_W), .RAW_W(RAW_W), .PIX_W(PIX_W), .DW(DW)) u_off (
      .pix_mode   (pix_mode_i),
      .raw_line   (raw_line_i),
      .raw_pix    (raw_pix_i),
      .htotal     (htotal_i),
      .hsync_start(hsync_start_i),
      .vtotal     (vtotal_i),
      .dividend   (off_num),
      .modulus    (off_mod)
   );

   always_comb begin
      div_go  = 1'b0;
      div_num = off_num;
      div_den = off_mod;
      if (accept) begin
         div_go = 1'b1;
      end else if (state_q == ST_WRAP && div_fin && mode_q) begin
         div_go  = 1'b1;
         div_num = div_rem;
         div_den = DW'(htot_q);
      end
   end

   spr_divider #(.DW(DW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (div_num),
      .den  (div_den),
      .fin  (div_fin),
      .quo  (div_quo),
      .rem  (div_rem)
   );

   logic unused_quo;
   assign unused_quo = ^div_quo[DW-1:LINE_W];

   spr_window #(.LINE_W(LINE_W), .DW(DW)) u_win (
      .pix_mode (mode_q),
      .pos      (pos_q),
      .line     (line_q),
      .htotal   (htot_q),
      .vtotal   (vtot_q),
      .vbl_start(vbs_q),
      .vbl_end  (vbe_q),
      .in_vbl   (win_in),
      .vpos     (win_vpos)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mode_q      <= 1'b0;
         htot_q      <= '0;
         vtot_q      <= '0;
         vbs_q       <= '0;
         vbe_q       <= '0;
         pos_q       <= '0;
         line_q      <= '0;
         hp_q        <= '0;
         vpos_o      <= '0;
         hpos_o      <= '0;
         in_vblank_o <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= pix_mode_i;
                  htot_q  <= htotal_i;
                  vtot_q  <= vtotal_i;
                  vbs_q   <= vbl_start_i;
                  vbe_q   <= vbl_end_i;
                  state_q <= ST_WRAP;
               end
            end
            ST_WRAP: begin
               if (div_fin) begin
                  pos_q <= div_rem;
                  if (mode_q) begin
                     state_q <= ST_SPLIT;
                  end else begin
                     line_q  <= div_rem[LINE_W-1:0];
                     hp_q    <= '0;
                     state_q <= ST_JUDGE;
                  end
               end
            end
            ST_SPLIT: begin
               if (div_fin) begin
                  line_q  <= div_quo[LINE_W-1:0];
                  hp_q    <= div_rem[LINE_W-1:0];
                  state_q <= ST_JUDGE;
               end
            end
            ST_JUDGE: begin
               vpos_o      <= win_vpos;
               hpos_o      <= hp_q;
               in_vblank_o <= win_in;
               state_q     <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
   parameter int unsigned LINE_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start_i,
   input logic                   busy_o,
   input logic                   done_o,
   input logic                   mode_q,
   input logic [LINE_W-1:0]      htot_q,
   input logic signed [LINE_W:0] vpos_o,
   input logic [LINE_W-1:0]      hpos_o,
   input logic                   in_vblank_o
);
   // R6: an accepted start makes the block busy on the next cycle
   p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R6: done lasts one cycle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: done is raised only inside a busy request
   p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R6: results move only in the done cycle
   p_hold_results_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(vpos_o) && $stable(hpos_o) && $stable(in_vblank_o)));

   // R1: line mode never reports a pixel
   p_line_mode_hpos_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !mode_q) |-> (hpos_o == '0));

   // R2: pixel lies inside the line
   p_pixel_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q) |-> (hpos_o < htot_q));

   // R5: the sign of the line matches the vblank flag
   p_sign_matches_vbl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (in_vblank_o == vpos_o[LINE_W]));
endmodule

bind scanpos_resolver spr_checker #(.LINE_W(LINE_W)) u_spr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .mode_q     (mode_q),
   .htot_q     (htot_q),
   .vpos_o     (vpos_o),
   .hpos_o     (hpos_o),
   .in_vblank_o(in_vblank_o)
);

// File: tb/scanpos_resolver_test.sv
`timescale 1ns/1ps
module scanpos_resolver_test;
   localparam int LW = 12;
   localparam int RW = 13;
   localparam int PW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic pix_mode_i = 1'b0;
   logic [RW-1:0] raw_line_i = '0;
   logic [PW-1:0] raw_pix_i = '0;
   logic [LW-1:0] htotal_i = '0, hsync_start_i = '0, vtotal_i = '0, vbl_start_i = '0, vbl_end_i = '0;
   logic busy_o, done_o, in_vblank_o;
   logic signed [LW:0] vpos_o;
   logic [LW-1:0] hpos_o;

   always #2.5 clk = ~clk;

   scanpos_resolver #(.LINE_W(LW), .RAW_W(RW), .PIX_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pix_mode_i(pix_mode_i),
      .raw_line_i(raw_line_i), .raw_pix_i(raw_pix_i), .htotal_i(htotal_i),
      .hsync_start_i(hsync_start_i), .vtotal_i(vtotal_i), .vbl_start_i(vbl_start_i),
      .vbl_end_i(vbl_end_i), .busy_o(busy_o), .done_o(done_o), .vpos_o(vpos_o),
      .hpos_o(hpos_o), .in_vblank_o(in_vblank_o)
   );

   typedef struct {
      string tag;
      int    vp;
      int    hp;
      bit    iv;
   } exp_t;

   exp_t exp_q[$];
   int   errors = 0;
   int   checks = 0;
   int   results = 0;
   bit   finished = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input bit pm, input int raw, input int ht, input int hs,
                                  input int vt, input int vbs, input int vbe, input string tag);
      exp_t e;
      int pos, line, hp, scale;
      bit ge, lt, inv;
      if (pm) begin
         pos   = (raw + ht - hs) % (ht * vt);
         line  = pos / ht;
         hp    = pos % ht;
         scale = ht;
      end else begin
         pos   = ((raw & ((1 << LW) - 1)) + 1) % vt;
         line  = pos;
         hp    = 0;
         scale = 1;
      end
      ge  = (pos >= vbs * scale);
      lt  = (pos < vbe * scale);
      inv = (vbs >= vbe) ? (ge || lt) : (ge && lt);
      e.tag = tag;
      e.vp  = inv ? line - vt : line;
      e.hp  = hp;
      e.iv  = inv;
      return e;
   endfunction

   task automatic drive(input bit pm, input int raw, input int ht, input int hs, input int vt,
                        input int vbs, input int vbe);
      pix_mode_i    = pm;
      raw_line_i    = RW'(raw);
      raw_pix_i     = PW'(raw);
      htotal_i      = LW'(ht);
      hsync_start_i = LW'(hs);
      vtotal_i      = LW'(vt);
      vbl_start_i   = LW'(vbs);
      vbl_end_i     = LW'(vbe);
   endtask

   task automatic send(input bit pm, input int raw, input int ht, input int hs, input int vt,
                       input int vbs, input int vbe, input string tag);
      @(negedge clk);
      while (busy_o) @(negedge clk);
      drive(pm, raw, ht, hs, vt, vbs, vbe);
      start_i = 1'b1;
      exp_q.push_back(model(pm, raw, ht, hs, vt, vbs, vbe, tag));
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R6 busy after start", int'(busy_o), 1);
   endtask

   // Monitor: pop expected items as results appear; check the hold afterwards (R6)
   initial begin
      exp_t cur;
      bit   have = 1'b0;
      bit   after = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && done_o) begin
            results++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
               cur  = exp_q.pop_front();
               have = 1'b1;
               check(int'(vpos_o) == cur.vp, {cur.tag, " vpos"}, int'(vpos_o), cur.vp);
               check(int'(hpos_o) == cur.hp, {cur.tag, " hpos"}, int'(hpos_o), cur.hp);
               check(in_vblank_o == cur.iv, {cur.tag, " in_vblank"}, int'(in_vblank_o), int'(cur.iv));
            end
            after = 1'b1;
         end else if (after && have) begin
            after = 1'b0;
            check(int'(vpos_o) == cur.vp && int'(hpos_o) == cur.hp && in_vblank_o == cur.iv,
                  "R6 outputs hold after done", int'(vpos_o), cur.vp);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check(busy_o == 1'b0, "R8 busy at reset", int'(busy_o), 0);
      check(done_o == 1'b0, "R8 done at reset", int'(done_o), 0);
      check(vpos_o == '0, "R8 vpos at reset", int'(vpos_o), 0);
      check(hpos_o == '0, "R8 hpos at reset", int'(hpos_o), 0);
      check(in_vblank_o == 1'b0, "R8 in_vblank at reset", int'(in_vblank_o), 0);
      rst_n = 1'b1;

      // Timing A: htotal 20, hsync 14, vtotal 12, vblank lines 8..11
      send(1'b0, 11, 20, 14, 12, 8, 12, "R1 last line wraps");
      send(1'b0, 4096 + 7, 20, 14, 12, 8, 12, "R1 masked high bit, R4 R5 in vblank");
      send(1'b0, 30, 20, 14, 12, 8, 12, "R1 modulo past vtotal");
      send(1'b1, 20 * 7 + 14, 20, 14, 12, 8, 12, "R3 vblank-start sync edge");
      send(1'b1, 20 * 7 + 13, 20, 14, 12, 8, 12, "R3 pixel before sync edge");
      send(1'b1, 239, 20, 14, 12, 8, 12, "R2 last pixel of frame");
      send(1'b1, 1000, 20, 14, 12, 8, 12, "R2 multi-frame count");
      for (int i = 0; i < 24; i++) begin
         send(1'b1, i * 37 + 3, 20, 14, 12, 8, 12, "R2 sweep");
      end

      // Timing B: wrapped vblank, lines 10..11 and 0..1
      send(1'b1, 30, 20, 14, 12, 10, 2, "R4 wrapped low side, R5");
      send(1'b1, 20 * 5 + 2, 20, 14, 12, 10, 2, "R4 wrapped active");
      send(1'b0, 4, 20, 14, 12, 10, 2, "R4 wrapped line active");
      send(1'b0, 9, 20, 14, 12, 10, 2, "R4 wrapped line high side, R5");

      // R7: a second start during busy must be ignored
      send(1'b1, 20 * 3 + 5, 20, 14, 12, 8, 12, "R7 first request kept");
      repeat (5) @(negedge clk);
      drive(1'b0, 3, 30, 2, 20, 1, 5);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (4) @(negedge clk);
      check(busy_o == 1'b0, "R7 no restart from ignored start", int'(busy_o), 0);
      check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
      check(results == 36, "R7 done count", results, 36);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule